// File: doc/BRIEF.md
# DSP Register–Memory Single-Transfer Unit

This block executes one data move per cycle between a small DSP register file and a synchronous memory port. Each 16-bit opcode chooses one of four address pointers, one of sixteen data registers, a transfer width of a 16-bit word or a 32-bit long, a direction, and one of four addressing modes. The block forms the access address, steps the pointer before or after the access, formats word data into the upper half of the register, and drives the memory request.

Two data-register slots are 8-bit guard registers. On a read they appear as sign-extended 32-bit values. On a write they keep only bits [7:0]. Memory read data arrives in the same cycle as the request, so every register update lands on the following clock edge. An opcode outside the transfer class is flagged as illegal and has no other effect.

Top module: `dsp_xfer_unit`

## Requirements
- R1: An opcode is accepted only when `instr_valid_i` is high and bits [15:10] equal 111101. In an accepted opcode, bits [9:8] pick the pointer, bits [7:4] pick the data register, bits [3:2] give the mode and bits [1:0] give size and direction. When `instr_valid_i` is low, there is no access and no state change.
- R2: Mode 00 is pre-decrement. The access address is the pointer minus 2 for a word or minus 4 for a long, taken modulo 2^32. That address is also written back to the pointer.
- R3: Mode 01 is plain indirect. The access address is the pointer, and the pointer is not changed.
- R4: Mode 10 is post-increment. The access address is the old pointer. Afterwards the pointer becomes the old pointer plus 2 for a word or plus 4 for a long.
- R5: Mode 11 is post-index. The access address is the old pointer. Afterwards the pointer becomes the old pointer plus `idx_i`, modulo 2^32.
- R6: Op 00 is a word load. `mem_long_o` is 0, and the register becomes {`mem_rdata_i`[15:0], 16'h0000}.
- R7: Op 10 is a long load. `mem_long_o` is 1, and the register becomes `mem_rdata_i`.
- R8: Op 01 is a word store and op 11 is a long store. Both raise `mem_we_o`. A word store drives {16'h0000, reg[31:16]} with `mem_long_o` 0. A long store drives the full register with `mem_long_o` 1.
- R9: Data registers 12 and 13 are 8-bit guard registers. A store reads them as bits [7:0] sign-extended into bits [31:8]. A load keeps bits [7:0] of the formatted load value.
- R10: An accepted-valid opcode whose bits [15:10] are not 111101 raises `illegal_o` in that cycle. It makes no memory request and updates no register.
- R11: Reset clears all pointers and data registers to zero. A new opcode can be issued every cycle, and each one sees the updates made by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Opcode |
| instr_valid_i | input | 1 | Opcode present this cycle |
| idx_i | input | 32 | Index register value used by mode 11 |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_long_o | output | 1 | 1: 32-bit access, 0: 16-bit access |
| mem_addr_o | output | 32 | Access address |
| mem_wdata_o | output | 32 | Store data (a word uses bits [15:0]) |
| mem_rdata_i | input | 32 | Read data, same cycle (a word uses bits [15:0]) |
| illegal_o | output | 1 | Opcode not in the transfer class |

## Verification
The memory request, address, store data and illegal flag are combinational from the opcode. The bench therefore samples them in the same cycle, a short delay after it drives the inputs at the falling edge. Pointer and register updates take effect at the next rising edge, so each one is checked through the address or store data of a later opcode. Those checks always fall at least one edge after the opcode that caused the update.

// File: rtl/dsp_xfer_pkg.sv
package dsp_xfer_pkg;
  localparam logic [5:0] XFER_MAJOR = 6'b111101;

  typedef enum logic [1:0] {
    AM_PRE  = 2'b00,
    AM_IND  = 2'b01,
    AM_POST = 2'b10,
    AM_IDX  = 2'b11
  } amode_e;

  typedef struct packed {
    logic       legal;
    logic [1:0] pfield;
    logic [3:0] rsel;
    amode_e     mode;
    logic       is_long;
    logic       is_store;
  } dec_t;
endpackage

// File: rtl/dsp_xfer_decode.sv
module dsp_xfer_decode
  import dsp_xfer_pkg::*;
(
  input  logic [15:0] instr_i,
  input  logic        valid_i,
  output dec_t        dec_o,
  output logic        illegal_o
);
  logic match;
  assign match = (instr_i[15:10] == XFER_MAJOR);

  always_comb begin
    dec_o.legal    = valid_i && match;
    dec_o.pfield   = instr_i[9:8];
    dec_o.rsel     = instr_i[7:4];
    dec_o.mode     = amode_e'(instr_i[3:2]);
    dec_o.is_long  = instr_i[1];
    dec_o.is_store = instr_i[0];
  end

  assign illegal_o = valid_i && !match;
endmodule

// File: rtl/dsp_xfer_agu.sv
module dsp_xfer_agu
  import dsp_xfer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] idx_i,
  input  amode_e        mode_i,
  input  logic          is_long_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] ptr_nxt_o,
  output logic          ptr_we_o
);
  logic [AW-1:0] step;
  assign step = is_long_i ? AW'(4) : AW'(2);

  always_comb begin
    addr_o    = ptr_i;
    ptr_nxt_o = ptr_i;
    ptr_we_o  = 1'b1;
    unique case (mode_i)
      AM_PRE: begin
        addr_o    = ptr_i - step;
        ptr_nxt_o = ptr_i - step;
      end
      AM_IND:  ptr_we_o  = 1'b0;
      AM_POST: ptr_nxt_o = ptr_i + step;
      AM_IDX:  ptr_nxt_o = ptr_i + idx_i;
      default: ptr_we_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsp_xfer_regs.sv
module dsp_xfer_regs #(
  parameter int DW      = 32,
  parameter int GW      = 8,
  parameter int NPTR    = 4,
  parameter int NDAT    = 16,
  parameter int GUARD_A = 12,
  parameter int GUARD_B = 13,
  localparam int PSEL_W = $clog2(NPTR),
  localparam int DSEL_W = $clog2(NDAT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PSEL_W-1:0] ptr_sel_i,
  input  logic              ptr_we_i,
  input  logic [DW-1:0]     ptr_wdata_i,
  output logic [DW-1:0]     ptr_rdata_o,
  input  logic [DSEL_W-1:0] dat_sel_i,
  input  logic              dat_we_i,
  input  logic [DW-1:0]     dat_wdata_i,
  output logic [DW-1:0]     dat_rdata_o
);
  logic [DW-1:0] ptr_q [NPTR];
  logic [DW-1:0] dat_rd [NDAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPTR; i++) ptr_q[i] <= '0;
    end else if (ptr_we_i) begin
      ptr_q[ptr_sel_i] <= ptr_wdata_i;
    end
  end
  assign ptr_rdata_o = ptr_q[ptr_sel_i];

  for (genvar i = 0; i < NDAT; i++) begin : g_dat
    if (i == GUARD_A || i == GUARD_B) begin : g_grd
      logic [GW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (dat_we_i && dat_sel_i == DSEL_W'(i)) q <= dat_wdata_i[GW-1:0];
      end
      assign dat_rd[i] = {{(DW-GW){q[GW-1]}}, q};
    end else begin : g_full
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (dat_we_i && dat_sel_i == DSEL_W'(i)) q <= dat_wdata_i;
      end
      assign dat_rd[i] = q;
    end
  end
  assign dat_rdata_o = dat_rd[dat_sel_i];
endmodule

// File: rtl/dsp_xfer_unit.sv
module dsp_xfer_unit
  import dsp_xfer_pkg::*;
#(
  parameter int DW      = 32,
  parameter int GW      = 8,
  parameter int NPTR    = 4,
  parameter int NDAT    = 16,
  parameter int GUARD_A = 12,
  parameter int GUARD_B = 13,
  parameter logic [3:0][1:0] PTR_MAP = {2'd3, 2'd2, 2'd1, 2'd0}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [15:0]   instr_i,
  input  logic          instr_valid_i,
  input  logic [DW-1:0] idx_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_long_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          illegal_o
);
  localparam int HW     = DW / 2;
  localparam int PSEL_W = $clog2(NPTR);

  dec_t          dec;
  logic [DW-1:0] ptr_cur, ptr_nxt, reg_cur, load_val;
  logic          agu_we;

  dsp_xfer_decode u_dec (
    .instr_i   (instr_i),
    .valid_i   (instr_valid_i),
    .dec_o     (dec),
    .illegal_o (illegal_o)
  );

  dsp_xfer_agu #(.AW(DW)) u_agu (
    .ptr_i     (ptr_cur),
    .idx_i     (idx_i),
    .mode_i    (dec.mode),
    .is_long_i (dec.is_long),
    .addr_o    (mem_addr_o),
    .ptr_nxt_o (ptr_nxt),
    .ptr_we_o  (agu_we)
  );

  dsp_xfer_regs #(
    .DW(DW), .GW(GW), .NPTR(NPTR), .NDAT(NDAT),
    .GUARD_A(GUARD_A), .GUARD_B(GUARD_B)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ptr_sel_i   (PSEL_W'(PTR_MAP[dec.pfield])),
    .ptr_we_i    (dec.legal && agu_we),
    .ptr_wdata_i (ptr_nxt),
    .ptr_rdata_o (ptr_cur),
    .dat_sel_i   (dec.rsel),
    .dat_we_i    (dec.legal && !dec.is_store),
    .dat_wdata_i (load_val),
    .dat_rdata_o (reg_cur)
  );

  // word moves use the upper register half
  assign load_val    = dec.is_long ? mem_rdata_i : {mem_rdata_i[HW-1:0], {HW{1'b0}}};
  assign mem_wdata_o = dec.is_long ? reg_cur : {{HW{1'b0}}, reg_cur[DW-1:HW]};
  assign mem_req_o   = dec.legal;
  assign mem_we_o    = dec.legal && dec.is_store;
  assign mem_long_o  = dec.is_long;

  p_illegal_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!mem_req_o && !mem_we_o));

  p_pre_wb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mem_req_o && dec.mode == AM_PRE) &&
     mem_req_o && dec.mode == AM_IND && dec.pfield == $past(dec.pfield))
    |-> mem_addr_o == $past(mem_addr_o));

  p_post_wb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mem_req_o && dec.mode == AM_POST) &&
     mem_req_o && dec.mode == AM_IND && dec.pfield == $past(dec.pfield))
    |-> mem_addr_o == $past(mem_addr_o) + ($past(mem_long_o) ? DW'(4) : DW'(2)));

  p_word_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mem_req_o && !mem_we_o && !mem_long_o) &&
     mem_we_o && mem_long_o && dec.rsel == $past(dec.rsel) &&
     int'(dec.rsel) != GUARD_A && int'(dec.rsel) != GUARD_B)
    |-> mem_wdata_o == {$past(mem_rdata_i[HW-1:0]), {HW{1'b0}}});

  p_guard_sext_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_long_o && (int'(dec.rsel) == GUARD_A || int'(dec.rsel) == GUARD_B))
    |-> mem_wdata_o[DW-1:GW] == {(DW-GW){mem_wdata_o[GW-1]}});
endmodule

// File: tb/dsp_xfer_unit_tb_top.sv
module dsp_xfer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        vld = 1'b0;
  logic [31:0] idx = '0, rdata = '0;
  logic        req, we, lng, ill;
  logic [31:0] addr, wdata;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  dsp_xfer_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .instr_valid_i(vld),
    .idx_i(idx), .mem_req_o(req), .mem_we_o(we), .mem_long_o(lng),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .illegal_o(ill)
  );

  typedef struct packed {
    logic [15:0] ins;
    logic        v;
    logic [31:0] rd;
    logic [31:0] ix;
    logic        e_req;
    logic        e_we;
    logic        e_lng;
    logic        e_ill;
    logic [31:0] e_addr;
    logic [31:0] e_wd;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{16'hF41A, 1'b1, 32'h12345678, 32'h0,        1'b1, 1'b0, 1'b1, 1'b0, 32'h00000000, 32'h0,        8'd7 },  // R7 R4
    '{16'hF417, 1'b1, 32'h0,        32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h00000004, 32'h12345678, 8'd8 },  // R8 R3
    '{16'hF420, 1'b1, 32'h0000ABCD, 32'h0,        1'b1, 1'b0, 1'b0, 1'b0, 32'h00000002, 32'h0,        8'd2 },  // R2
    '{16'hF427, 1'b1, 32'h0,        32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h00000002, 32'hABCD0000, 8'd6 },  // R6
    '{16'hF419, 1'b1, 32'h0,        32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 32'h00000002, 32'h00001234, 8'd8 },  // R8 word
    '{16'hF5C2, 1'b1, 32'h00000080, 32'h0,        1'b1, 1'b0, 1'b1, 1'b0, 32'hFFFFFFFC, 32'h0,        8'd2 },  // R2 wrap
    '{16'hF5C7, 1'b1, 32'h0,        32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFFFFFC, 32'hFFFFFF80, 8'd9 },  // R9
    '{16'hF5CD, 1'b1, 32'h0,        32'h10,       1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFFFFFC, 32'h0000FFFF, 8'd9 },  // R9 R5
    '{16'hF000, 1'b1, 32'hDEADBEEF, 32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 32'h0,        32'h0,        8'd10},  // R10
    '{16'hF407, 1'b1, 32'h0,        32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h00000004, 32'h00000000, 8'd10},  // R10 no update
    '{16'hF5D7, 1'b1, 32'h0,        32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h0000000C, 32'h00000000, 8'd5 },  // R5 wrap sum
    '{16'hF6DE, 1'b1, 32'h0000007F, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b1, 1'b0, 32'h00000000, 32'h0,        8'd5 },  // R5
    '{16'hF6D3, 1'b1, 32'h0,        32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFFFFFA, 32'h0000007F, 8'd9 },  // R9 R2
    '{16'hF41A, 1'b0, 32'hCAFEF00D, 32'h0,        1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h0,        8'd1 },  // R1 not valid
    '{16'hF417, 1'b1, 32'h0,        32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h00000004, 32'h12345678, 8'd1 }   // R1 unchanged
  };

  task automatic chk(input string what, input int tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic issue(input logic [15:0] i, input logic v, input logic [31:0] r, input logic [31:0] x);
    @(negedge clk);
    instr = i; vld = v; rdata = r; idx = x;
    #2;
  endtask

  initial begin
    #(8 * 50000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R11: reset state
    issue(16'h0, 1'b0, '0, '0);
    chk("idle req", 11, {31'b0, req}, 32'h0);
    chk("idle illegal", 11, {31'b0, ill}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    issue(16'hF737, 1'b1, '0, '0);
    chk("reset ptr", 11, addr, 32'h0);
    chk("reset data", 11, wdata, 32'h0);

    // table walk, each opcode back to back (R11)
    for (int k = 0; k < NV; k++) begin
      issue(VECS[k].ins, VECS[k].v, VECS[k].rd, VECS[k].ix);
      chk("req", VECS[k].tag, {31'b0, req}, {31'b0, VECS[k].e_req});
      chk("we", VECS[k].tag, {31'b0, we}, {31'b0, VECS[k].e_we});
      chk("illegal", VECS[k].tag, {31'b0, ill}, {31'b0, VECS[k].e_ill});
      if (VECS[k].e_req) begin
        chk("long", VECS[k].tag, {31'b0, lng}, {31'b0, VECS[k].e_lng});
        chk("addr", VECS[k].tag, addr, VECS[k].e_addr);
      end
      if (VECS[k].e_we) chk("wdata", VECS[k].tag, wdata, VECS[k].e_wd);
    end

    // R6: word load into a different pointer, upper half then long store
    issue(16'hF738, 1'b1, 32'hFFFF1357, '0);  // word load A3 D3 post
    issue(16'hF737 & 16'hFFF0 | 16'h0007 | 16'h0030, 1'b1, '0, '0);
    chk("word load format", 6, wdata, 32'h13570000);
    chk("post step word", 4, addr, 32'h00000002);

    // R11: mid-run reset clears state
    @(negedge clk) begin vld = 1'b0; rst_n = 1'b0; end
    @(negedge clk) rst_n = 1'b1;
    issue(16'hF417, 1'b1, '0, '0);
    chk("reset ptr again", 11, addr, 32'h0);
    chk("reset data again", 11, wdata, 32'h0);

    @(negedge clk) vld = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule